// File: doc/BRIEF.md
# Periodic Data-Link Message Transmitter

This block turns a stored data-link message into an HDLC-style bit stream for a slow overhead channel inside an outgoing line frame. The line framer pulses `dl_slot` once for each data-link bit position, and the block presents exactly one new serial bit on `dl_bit` per pulse. When no message is being sent, the output carries a continuous train of flag octets (0x7E).

A host writes two byte-wide registers over a simple read/write bus. One holds the enable. The other holds the start, busy and interrupt bits. When the host raises the start bit, the block builds the frame by itself. It sends an opening flag, three fixed header octets, and the payload bytes read from an external synchronous buffer through `buf_addr`/`buf_data`, with `msg_len` giving the payload length. It then sends a 16-bit frame check sequence and a closing flag. Zero stuffing is applied to the payload bits only.

Once the first frame has gone out, each one-second tick on `sec_tick` sends the same message again until the enable is cleared. A clear-on-read interrupt status bit and the `irq` output report each completed frame.

Top module: `dl_msg_tx`

## Requirements
- R1: After reset the block is disabled, and the configuration register (address 1Eh, bit 0 = enable) reads 00h. While disabled, raising the start bit sends nothing and the output stays on flags. An idle, disabled block never becomes busy.
- R2: A frame is launched only by a 0-to-1 change of bit 3 (start) of the status register at address 1Fh. Writing 1 to that bit while it already holds 1 launches nothing.
- R3: Bit 2 of the status register is a read-only busy flag. It reads 1 from the launch of a frame until its closing flag has been sent, and 0 afterwards.
- R4: Status bit 1 is a read/write interrupt enable. Status bit 0 is set when a frame completes and is cleared by any read of the status register. Writes do not affect bit 0. `irq` equals bit 0 AND bit 1. Status bits 7..4 and configuration bits 7..1 read 0. The status register reads 00h after reset.
- R5: A frame is sent in this order: flag 7Eh, the header octets SAPI (default 3Ch), TEI (default 01h) and control (default 03h), payload bytes from buffer addresses 0 to `msg_len`-1, the FCS low octet, the FCS high octet, and a closing flag 7Eh. Every octet goes out least significant bit first. A `msg_len` of 0 sends no payload.
- R6: The FCS is a CRC-16 with generator x^16+x^12+x^5+1 and initial value FFFFh. It is computed LSB first over the three header octets and the payload, excluding the flags and any stuffed bits. It is sent ones-complemented, low octet first.
- R7: Within the payload, a 0 bit is inserted after every run of five 1 bits. The run count carries across payload octet boundaries. A stuffed 0 that follows the last payload bit is sent before the FCS. Header, FCS and flag octets are never stuffed.
- R8: While idle, disabled or waiting between frames, the output is an unbroken sequence of 7Eh flags, aligned to the end of the preceding octet.
- R9: After the first frame completes, each `sec_tick` pulse while enabled resends the same message. A tick that arrives during a frame is held. The resend begins only after that frame's closing flag and at least one idle flag.
- R10: `dl_bit` resets to 0. It changes only on a clock edge at which `dl_slot` is high, and it advances by exactly one bit per such edge.
- R11: Clearing the enable takes effect at the next octet boundary. The output returns to flags, busy reads 0, no interrupt is raised for the aborted frame, and later ticks send nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Frame-complete interrupt |
| sec_tick | input | 1 | One-cycle pulse at each one-second boundary |
| dl_slot | input | 1 | Data-link bit slot strobe from the line framer |
| dl_bit | output | 1 | Serial data-link bit |
| msg_len | input | BUF_AW+1 | Payload length in bytes |
| buf_addr | output | BUF_AW | Payload buffer read address |
| buf_data | input | 8 | Payload buffer read data, one cycle after the address |

## Verification
On every cycle, the assertions check that `dl_bit` holds still without a slot strobe, that an idle and disabled transmitter never turns busy, that the interrupt status rises only right after busy falls, and that the unused status bits read zero. Frame content, FCS value, stuffing positions, the one-second resend, the holding of a tick that arrives mid-frame, and the abort on disable can only be shown by the bench scenarios. The bench decodes the captured bit stream against frames it builds itself from random and directed payloads.

// File: rtl/dl_pkg.sv
package dl_pkg;
  localparam logic [7:0]  FLAG_OCT = 8'h7E;
  localparam logic [15:0] CRC_POLY_R = 16'h8408;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;

  typedef enum logic [3:0] {
    K_IDLE, K_OPEN, K_HDR0, K_HDR1, K_HDR2, K_PAY, K_FCS0, K_FCS1, K_CLOSE
  } oct_kind_e;
endpackage

// File: rtl/dl_crc16.sv
module dl_crc16
  import dl_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        init,
  input  logic        en,
  input  logic        din,
  output logic [15:0] crc,
  output logic [15:0] crc_nxt
);
  always_comb begin
    crc_nxt = {1'b0, crc[15:1]} ^ ((crc[0] ^ din) ? CRC_POLY_R : 16'h0000);
  end

  always_ff @(posedge clk) begin
    if (rst || init) crc <= CRC_SEED;
    else if (en)     crc <= crc_nxt;
  end
endmodule

// File: rtl/dl_regs.sv
module dl_regs #(
  parameter int ADDR_W = 5,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 5'h1E,
  parameter logic [ADDR_W-1:0] STS_ADDR = 5'h1F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              busy,
  input  logic              done,
  output logic              en,
  output logic              start_rise,
  output logic              irq
);
  logic start_q, ie_q, ist_q, en_q, ie_d, ist_d, cfg_sel, sts_sel;
  logic unused_wbits;
  assign unused_wbits = ^{wdata[7:4], wdata[2]};
  assign en = en_q;

  always_comb begin
    cfg_sel = (addr == CFG_ADDR);
    sts_sel = (addr == STS_ADDR);
    ie_d    = (wr && sts_sel) ? wdata[1] : ie_q;
    if (done)                ist_d = 1'b1;
    else if (rd && sts_sel)  ist_d = 1'b0;
    else                     ist_d = ist_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0; ie_q <= 1'b0; ist_q <= 1'b0; en_q <= 1'b0;
      start_rise <= 1'b0; irq <= 1'b0; rdata <= 8'h00;
    end else begin
      start_rise <= wr && sts_sel && wdata[3] && !start_q;
      if (wr && cfg_sel) en_q <= wdata[0];
      if (wr && sts_sel) start_q <= wdata[3];
      ie_q  <= ie_d;
      ist_q <= ist_d;
      irq   <= ie_d && ist_d;
      if (rd) begin
        if (sts_sel)      rdata <= {4'h0, start_q, busy, ie_q, ist_q};
        else if (cfg_sel) rdata <= {7'h00, en_q};
        else              rdata <= 8'h00;
      end
    end
  end

  // R4
  int_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ist_q) |-> (!busy && $past(busy, 2)));

  // R4
  pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && sts_sel) |=> (rdata[7:4] == 4'h0));
endmodule

// File: rtl/dl_framer.sv
module dl_framer
  import dl_pkg::*;
#(
  parameter int AW = 6,
  parameter logic [7:0] SAPI = 8'h3C,
  parameter logic [7:0] TEI  = 8'h01,
  parameter logic [7:0] CTRL = 8'h03
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          start_rise,
  input  logic          tick,
  input  logic          slot,
  input  logic [AW:0]   msg_len,
  input  logic [7:0]    buf_data,
  output logic [AW-1:0] buf_addr,
  output logic          dl_bit,
  output logic          busy,
  output logic          done
);
  oct_kind_e   kind;
  logic [7:0]  oct;
  logic [2:0]  bitn, ones;
  logic        stuff_pend, go_pend, armed;
  logic [AW:0] pidx;
  logic [15:0] crc, crc_nxt;
  logic        cur_b, emit, bound, launch, crc_en;
  logic        unused_crc;
  assign unused_crc = ^{crc[7:0], crc_nxt[15:8]};

  always_comb begin
    cur_b  = oct[bitn];
    emit   = slot && !stuff_pend;
    bound  = emit && (bitn == 3'd7);
    launch = bound && en && go_pend && (kind == K_IDLE);
    crc_en = emit && (kind inside {K_HDR0, K_HDR1, K_HDR2, K_PAY});
  end

  dl_crc16 u_crc (
    .clk(clk), .rst(rst), .init(launch), .en(crc_en), .din(cur_b),
    .crc(crc), .crc_nxt(crc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      armed <= 1'b0; go_pend <= 1'b0;
    end else begin
      if (done) armed <= 1'b1;
      go_pend <= (go_pend && !launch) || start_rise || (tick && armed);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind <= K_IDLE; oct <= FLAG_OCT; bitn <= 3'd0; ones <= 3'd0;
      stuff_pend <= 1'b0; pidx <= '0; buf_addr <= '0;
      dl_bit <= 1'b0; busy <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (slot) dl_bit <= stuff_pend ? 1'b0 : cur_b;
      if (slot && stuff_pend) stuff_pend <= 1'b0;
      if (emit) begin
        bitn <= bitn + 3'd1;
        if (kind == K_PAY) begin
          if (!cur_b)              ones <= 3'd0;
          else if (ones == 3'd4) begin ones <= 3'd0; stuff_pend <= 1'b1; end
          else                     ones <= ones + 3'd1;
        end
      end
      if (bound) begin
        if (!en) begin
          kind <= K_IDLE; oct <= FLAG_OCT; busy <= 1'b0; stuff_pend <= 1'b0;
        end else begin
          unique case (kind)
            K_IDLE: if (go_pend) begin
              kind <= K_OPEN; busy <= 1'b1; ones <= 3'd0; buf_addr <= '0;
            end
            K_OPEN: begin kind <= K_HDR0; oct <= SAPI; end
            K_HDR0: begin kind <= K_HDR1; oct <= TEI;  end
            K_HDR1: begin kind <= K_HDR2; oct <= CTRL; end
            K_HDR2, K_PAY: begin
              if ((kind == K_HDR2) ? (msg_len == '0) : (pidx == msg_len)) begin
                kind <= K_FCS0; oct <= ~crc_nxt[7:0];
              end else begin
                kind <= K_PAY; oct <= buf_data;
                pidx <= (kind == K_HDR2) ? (AW+1)'(1) : pidx + 1'b1;
                buf_addr <= buf_addr + 1'b1;
              end
            end
            K_FCS0: begin kind <= K_FCS1; oct <= ~crc[15:8]; end
            K_FCS1: begin kind <= K_CLOSE; oct <= FLAG_OCT; end
            K_CLOSE: begin kind <= K_IDLE; busy <= 1'b0; done <= 1'b1; end
            default: begin kind <= K_IDLE; oct <= FLAG_OCT; busy <= 1'b0; end
          endcase
        end
      end
    end
  end

  // R10
  bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !slot |=> $stable(dl_bit));

  // R1
  idle_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !en) |=> !busy);
endmodule

// File: rtl/dl_msg_tx.sv
module dl_msg_tx #(
  parameter int ADDR_W = 5,
  parameter int BUF_AW = 6,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 5'h1E,
  parameter logic [ADDR_W-1:0] STS_ADDR = 5'h1F,
  parameter logic [7:0] SAPI = 8'h3C,
  parameter logic [7:0] TEI  = 8'h01,
  parameter logic [7:0] CTRL = 8'h03
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq,
  input  logic              sec_tick,
  input  logic              dl_slot,
  output logic              dl_bit,
  input  logic [BUF_AW:0]   msg_len,
  output logic [BUF_AW-1:0] buf_addr,
  input  logic [7:0]        buf_data
);
  logic en, start_rise, busy, done;

  dl_regs #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR), .STS_ADDR(STS_ADDR)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .busy(busy), .done(done),
    .en(en), .start_rise(start_rise), .irq(irq)
  );

  dl_framer #(.AW(BUF_AW), .SAPI(SAPI), .TEI(TEI), .CTRL(CTRL)) u_framer (
    .clk(clk), .rst(rst), .en(en), .start_rise(start_rise), .tick(sec_tick),
    .slot(dl_slot), .msg_len(msg_len), .buf_data(buf_data),
    .buf_addr(buf_addr), .dl_bit(dl_bit), .busy(busy), .done(done)
  );
endmodule

// File: tb/sim_dl_msg_tx.sv
`timescale 1ns/1ps
module sim_dl_msg_tx;
  localparam int AW = 6;
  localparam int CAP_N = 4096;
  localparam logic [4:0] CFG_A = 5'h1E;
  localparam logic [4:0] STS_A = 5'h1F;
  localparam logic [7:0] H_SAPI = 8'h3C, H_TEI = 8'h01, H_CTRL = 8'h03;

  logic clk = 1'b0, rst = 1'b1, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, buf_data = '0;
  logic [7:0] reg_rdata;
  logic irq, dl_bit;
  logic sec_tick = 1'b0, dl_slot = 1'b0;
  logic [AW:0] msg_len = '0;
  logic [AW-1:0] buf_addr;
  logic [7:0] mem [0:(1<<AW)-1];

  int n_chk = 0, n_bad = 0, ncap = 0, pos = 0, nexp = 0, mones = 0;
  bit cap [0:CAP_N-1];
  bit expb [0:1023];
  logic [15:0] mc;
  bit run_over = 1'b0;

  dl_msg_tx u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .sec_tick(sec_tick),
    .dl_slot(dl_slot), .dl_bit(dl_bit), .msg_len(msg_len), .buf_addr(buf_addr),
    .buf_data(buf_data)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) buf_data <= mem[buf_addr];

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) dl_slot = 1'b1;
      @(negedge clk);
      if (ncap < CAP_N) begin cap[ncap] = dl_bit; ncap++; end
      dl_slot = 1'b0;
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk) begin reg_wr = 1'b1; reg_addr = a; reg_wdata = d; end
    @(negedge clk) reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk) begin reg_rd = 1'b1; reg_addr = a; end
    @(negedge clk) reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic tick_pulse();
    @(negedge clk) sec_tick = 1'b1;
    @(negedge clk) sec_tick = 1'b0;
  endtask

  function automatic logic [7:0] oct_at(input int p);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = (p + i < CAP_N) ? cap[p + i] : 1'b0;
    return v;
  endfunction

  task automatic push_oct(input logic [7:0] v, input bit do_crc, input bit do_stuff);
    for (int i = 0; i < 8; i++) begin
      expb[nexp] = v[i]; nexp++;
      if (do_crc) begin
        if (mc[0] ^ v[i]) mc = (mc >> 1) ^ 16'h8408;
        else              mc = mc >> 1;
      end
      if (do_stuff) begin
        if (v[i]) begin
          mones++;
          if (mones == 5) begin expb[nexp] = 1'b0; nexp++; mones = 0; end
        end else mones = 0;
      end
    end
  endtask

  task automatic build_exp(input int len);
    logic [15:0] f;
    nexp = 0; mc = 16'hFFFF; mones = 0;
    push_oct(H_SAPI, 1'b1, 1'b0);
    push_oct(H_TEI, 1'b1, 1'b0);
    push_oct(H_CTRL, 1'b1, 1'b0);
    for (int i = 0; i < len; i++) push_oct(mem[i], 1'b1, 1'b1);
    f = ~mc;
    push_oct(f[7:0], 1'b0, 1'b0);
    push_oct(f[15:8], 1'b0, 1'b0);
    push_oct(8'h7E, 1'b0, 1'b0);
  endtask

  task automatic check_frame(input string what, output int nflag);
    int p, bad;
    p = pos; nflag = 0; bad = -1;
    while (p + 8 <= ncap && oct_at(p) == 8'h7E) begin p += 8; nflag++; end
    if (p + nexp > ncap) bad = 0;
    else for (int k = 0; k < nexp; k++) if (bad < 0 && cap[p + k] != expb[k]) bad = k;
    if (bad < 0) begin
      check(1'b1, what, 0, 0);
      pos = p + nexp;
    end else begin
      check(1'b0, what, longint'(oct_at(p + bad)), longint'(p + bad));
      pos = ncap;
    end
  endtask

  task automatic check_idle(input string what);
    int bad_at;
    bad_at = -1;
    while (pos + 8 <= ncap) begin
      if (bad_at < 0 && oct_at(pos) != 8'h7E) bad_at = pos;
      pos += 8;
    end
    check(bad_at < 0, what, (bad_at < 0) ? 64'h7E : longint'(oct_at(bad_at)), 64'h7E);
  endtask

  task automatic fill_random(input int len);
    for (int i = 0; i < len; i++)
      mem[i] = ($urandom % 3 == 0) ? 8'hFF : 8'($urandom);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!run_over) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic b0;
    int nf, len, sync;
    bit ok;
    for (int i = 0; i < (1 << AW); i++) mem[i] = 8'h00;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R10 / R4 reset values
    check(dl_bit == 1'b0, "R10 reset dl_bit", dl_bit, 0);
    check(irq == 1'b0, "R4 reset irq", irq, 0);
    bus_rd(CFG_A, d); check(d == 8'h00, "R1 config after reset", d, 8'h00);
    bus_rd(STS_A, d); check(d == 8'h00, "R4 status after reset", d, 8'h00);

    // R1 start while disabled
    bus_wr(STS_A, 8'h0A);
    strobes(40);
    check_idle("R1 disabled start sends only flags");
    bus_rd(STS_A, d); check(d == 8'h0A, "R1 disabled not busy", d, 8'h0A);
    bus_wr(STS_A, 8'h02);

    // R5 R6 R7 directed stuffing payload
    mem[0] = 8'hFF; mem[1] = 8'hFF; mem[2] = 8'hF8; mem[3] = 8'h1F;
    mem[4] = 8'h00; mem[5] = 8'h7E; mem[6] = 8'hFF; mem[7] = 8'h3E;
    msg_len = (AW+1)'(8); build_exp(8);
    bus_wr(CFG_A, 8'h01);
    bus_wr(STS_A, 8'h0A);
    strobes(20);
    bus_rd(STS_A, d); check(d[2] == 1'b1, "R3 busy during frame", d[2], 1);
    strobes(nexp + 8);
    check_frame("R5 R6 R7 directed frame", nf);
    check(irq == 1'b1, "R4 irq after frame", irq, 1);
    bus_rd(STS_A, d); check(d == 8'h0B, "R3 R4 status after frame", d, 8'h0B);
    bus_rd(STS_A, d); check(d == 8'h0A, "R4 clear on read", d, 8'h0A);
    check(irq == 1'b0, "R4 irq cleared", irq, 0);

    // R2 writing 1 again starts nothing
    bus_wr(STS_A, 8'h0A);
    strobes(48);
    check_idle("R2 R8 no frame on repeated 1");
    bus_rd(STS_A, d); check(d == 8'h0A, "R2 no completion", d, 8'h0A);

    // R9 tick resends same message
    tick_pulse();
    strobes(nexp + 24);
    check_frame("R9 one-second resend", nf);
    bus_rd(STS_A, d); check(d == 8'h0B, "R9 resend completes", d, 8'h0B);

    // R5 R6 empty payload
    bus_wr(STS_A, 8'h02);
    msg_len = '0; build_exp(0);
    bus_wr(STS_A, 8'h0A);
    strobes(nexp + 24);
    check_frame("R5 R6 zero-length payload", nf);
    bus_rd(STS_A, d);

    // R5 R6 R7 random payloads
    for (int f = 0; f < 6; f++) begin
      len = 1 + int'($urandom % 10);
      bus_wr(STS_A, 8'h02);
      fill_random(len);
      msg_len = (AW+1)'(len); build_exp(len);
      bus_wr(STS_A, 8'h0A);
      strobes(nexp + 24);
      check_frame("R5 R6 R7 random frame", nf);
      bus_rd(STS_A, d); check(d == 8'h0B, "R3 R4 random completion", d, 8'h0B);
    end

    // R9 tick during frame is held
    bus_wr(STS_A, 8'h02);
    for (int i = 0; i < 6; i++) mem[i] = 8'hFF;
    msg_len = (AW+1)'(6); build_exp(6);
    bus_wr(STS_A, 8'h0A);
    strobes(30);
    tick_pulse();
    strobes(2 * nexp + 48);
    check_frame("R9 frame with tick inside", nf);
    check_frame("R9 held resend", nf);
    check(nf >= 2, "R9 idle flag before held resend", nf, 2);
    bus_rd(STS_A, d);

    // R10 no strobe, no change
    b0 = dl_bit; ok = 1'b1;
    repeat (20) @(negedge clk) if (dl_bit != b0) ok = 1'b0;
    check(ok, "R10 stable without strobe", dl_bit, b0);

    // R11 disable mid-frame
    bus_wr(STS_A, 8'h02);
    fill_random(10);
    msg_len = (AW+1)'(10);
    bus_wr(STS_A, 8'h0A);
    strobes(40);
    bus_wr(CFG_A, 8'h00);
    strobes(24);
    bus_rd(STS_A, d); check(d == 8'h0A, "R11 not busy, no interrupt", d, 8'h0A);
    tick_pulse();
    strobes(72);
    sync = -1;
    for (int i = ncap - 72; i + 16 <= ncap; i++)
      if (sync < 0 && oct_at(i) == 8'h7E && oct_at(i + 8) == 8'h7E) sync = i;
    check(sync >= 0, "R11 flag train found", sync, 0);
    if (sync >= 0) begin
      pos = sync;
      check_idle("R11 R8 flags after disable and tick");
    end
    check(irq == 1'b0, "R11 no irq", irq, 0);

    run_over = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule